// File: doc/BRIEF.md
# Character Display Host Register Interface

This block is the register front end that a host processor sees on a character display controller. A single 8-bit parallel access port reaches two internal registers. The register-select input steers each access: select 0 addresses the write-only instruction register, or returns the status byte on a read. Select 1 addresses the data register. The block decodes a small instruction set. It keeps one address counter, which is shared by an internal display memory and a character-pattern memory.

The data register always holds a prefetched copy of the byte at the address counter, taken from whichever memory the last address-set instruction chose. A host read returns that copy, advances the counter and starts the next prefetch. After each accepted operation the block raises a busy flag for a fixed time. While the flag is up, further instruction writes and data accesses are dropped. The flag is reported on bit 7 of the status byte, so the host polls it before it issues the next command.

Clear display takes the longest. It refills the whole display memory with the blank character, one byte per clock, and sets the counter back to zero.

Top module: `chd_host_if`

## Requirements
- R1: After synchronous reset the busy flag is 0, the address counter is 0, the display memory is selected, and a status read returns 0x00.
- R2: Instruction codes are as follows. `1aaaaaaa` sets the display address to a. `01aaaaaa` sets the pattern address to a. `0x01` clears the display. `00010d00` shifts the cursor, right (+1) when d=1 and left (-1) when d=0. Any other code is accepted as a no-op.
- R3: Once a prefetch completes, the data register holds the byte at the address counter in the selected memory. A data read (select 1, read 1) returns that byte on `acc_rdata` one clock after the access. A prefetch follows every address set, cursor shift, data write and data read.
- R4: The most recent address-set instruction chooses the memory that data reads and writes use. Clear display chooses the display memory.
- R5: While busy is 1, instruction writes are ignored and data accesses change neither memory nor the address counter. A data read while busy still returns the current data register.
- R6: A status read (select 0, read 1) returns {busy, address counter[6:0]} on `acc_rdata` one clock after the access, whether or not the block is busy.
- R7: Each accepted data write or read advances the counter by one. The counter wraps at 128 for the display memory and at 64 for the pattern memory. Cursor shifts wrap in the same way, in both directions.
- R8: An accepted instruction other than clear holds busy for INS_CYCLES clocks. An accepted data access holds busy for the single clock of its prefetch.
- R9: Clear display writes 0x20 into every display location, one byte per clock, and sets the counter to 0. Busy stays 1 until the fill and the CLR_CYCLES count have both ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one clock per access |
| acc_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| acc_rnw | input | 1 | 1 read, 0 write |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte, valid the clock after a read access |

## Verification
Most wrong internal states in this block surface on the next status read, because that read exposes the busy flag and the address counter together one clock after it is issued. A wrong memory select or a stale prefetch shows up one clock after the next data read, as a wrong byte. A counter that fails to wrap shows up as a wrong address in the status byte straight after the boundary access. A busy flag that clears too early or too late shows up as a wrong poll count, or as a dropped instruction being accepted. That last case then moves the counter where the next status read can see it.

// File: rtl/chd_pkg.sv
package chd_pkg;

    localparam logic [7:0] BLANK_CODE = 8'h20;
    localparam int         FIELD_W    = 7;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_SET_DISP,
        OP_SET_PAT,
        OP_CLEAR,
        OP_SHIFT
    } op_e;

    typedef struct packed {
        op_e                op;
        logic               right;
        logic [FIELD_W-1:0] addr;
    } instr_t;

    function automatic instr_t decode_instr(input logic [7:0] code);
        instr_t d;
        d.op    = OP_NOP;
        d.right = code[2];
        d.addr  = code[FIELD_W-1:0];
        if (code[7])                        d.op = OP_SET_DISP;
        else if (code[6])                   d.op = OP_SET_PAT;
        else if (code == 8'h01)             d.op = OP_CLEAR;
        else if (code[5:3] == 3'b010 && code[1:0] == 2'b00)
                                            d.op = OP_SHIFT;
        return d;
    endfunction

endpackage

// File: rtl/chd_decode.sv
module chd_decode
    import chd_pkg::*;
(
    input  logic [7:0] code,
    output instr_t     instr
);
    always_comb instr = decode_instr(code);
endmodule

// File: rtl/chd_ram.sv
module chd_ram #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/chd_busy.sv
module chd_busy #(
    parameter int INS_CYCLES = 6,
    parameter int CLR_CYCLES = 132
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic long_op,
    output logic active
);
    localparam int CW = $clog2(CLR_CYCLES + 1);
    localparam logic [CW-1:0] SHORT_V = CW'(INS_CYCLES);
    localparam logic [CW-1:0] LONG_V  = CW'(CLR_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (load)          cnt <= long_op ? LONG_V : SHORT_V;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);
endmodule

// File: rtl/chd_host_if.sv
module chd_host_if
    import chd_pkg::*;
#(
    parameter int DD_AW      = 7,
    parameter int CG_AW      = 6,
    parameter int INS_CYCLES = 6,
    parameter int CLR_CYCLES = 132
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_valid,
    input  logic       acc_rs,
    input  logic       acc_rnw,
    input  logic [7:0] acc_wdata,
    output logic [7:0] acc_rdata
);
    localparam int               DD_DEPTH = 1 << DD_AW;
    localparam logic [DD_AW-1:0] CG_MASK  = DD_AW'((1 << CG_AW) - 1);
    localparam logic [DD_AW-1:0] LAST_DD  = DD_AW'(DD_DEPTH - 1);

    logic [DD_AW-1:0] ac_q;
    logic             sel_cg;
    logic [7:0]       dr_q;
    logic             pf_pend;
    logic             fill_on;
    logic [DD_AW-1:0] fill_ptr;
    logic             cnt_busy;
    logic             busy;

    instr_t           instr;
    logic             instr_acc, dwr_acc, drd_acc, stat_rd, drd_any;
    logic [7:0]       dd_rbyte, cg_rbyte;
    logic             dd_we, cg_we;
    logic [DD_AW-1:0] dd_waddr;
    logic [7:0]       dd_wbyte;

    function automatic logic [DD_AW-1:0] step_ac(input logic [DD_AW-1:0] a,
                                                 input logic up,
                                                 input logic cg);
        logic [DD_AW-1:0] n;
        n = up ? a + 1'b1 : a - 1'b1;
        if (cg) n = n & CG_MASK;
        return n;
    endfunction

    assign busy      = cnt_busy | fill_on | pf_pend;
    assign instr_acc = acc_valid & ~acc_rs & ~acc_rnw & ~busy;
    assign dwr_acc   = acc_valid &  acc_rs & ~acc_rnw & ~busy;
    assign drd_any   = acc_valid &  acc_rs &  acc_rnw;
    assign drd_acc   = drd_any & ~busy;
    assign stat_rd   = acc_valid & ~acc_rs &  acc_rnw;

    chd_decode u_dec (.code(acc_wdata), .instr(instr));

    chd_busy #(.INS_CYCLES(INS_CYCLES), .CLR_CYCLES(CLR_CYCLES)) u_busy (
        .clk    (clk),
        .rst    (rst),
        .load   (instr_acc),
        .long_op(instr.op == OP_CLEAR),
        .active (cnt_busy)
    );

    assign dd_we    = fill_on | (dwr_acc & ~sel_cg);
    assign dd_waddr = fill_on ? fill_ptr : ac_q;
    assign dd_wbyte = fill_on ? BLANK_CODE : acc_wdata;
    assign cg_we    = dwr_acc & sel_cg;

    chd_ram #(.AW(DD_AW), .DW(8)) u_dd (
        .clk  (clk),
        .we   (dd_we),
        .waddr(dd_waddr),
        .wdata(dd_wbyte),
        .raddr(ac_q),
        .rdata(dd_rbyte)
    );

    chd_ram #(.AW(CG_AW), .DW(8)) u_cg (
        .clk  (clk),
        .we   (cg_we),
        .waddr(ac_q[CG_AW-1:0]),
        .wdata(acc_wdata),
        .raddr(ac_q[CG_AW-1:0]),
        .rdata(cg_rbyte)
    );

    // Address counter, memory select and prefetch request
    always_ff @(posedge clk) begin
        if (rst) begin
            ac_q     <= '0;
            sel_cg   <= 1'b0;
            pf_pend  <= 1'b1;
            fill_on  <= 1'b0;
            fill_ptr <= '0;
        end else begin
            if (pf_pend) pf_pend <= 1'b0;
            if (fill_on) begin
                fill_ptr <= fill_ptr + 1'b1;
                if (fill_ptr == LAST_DD) begin
                    fill_on <= 1'b0;
                    pf_pend <= 1'b1;
                end
            end
            if (instr_acc) begin
                unique case (instr.op)
                    OP_SET_DISP: begin
                        ac_q    <= instr.addr[DD_AW-1:0];
                        sel_cg  <= 1'b0;
                        pf_pend <= 1'b1;
                    end
                    OP_SET_PAT: begin
                        ac_q    <= instr.addr[DD_AW-1:0] & CG_MASK;
                        sel_cg  <= 1'b1;
                        pf_pend <= 1'b1;
                    end
                    OP_SHIFT: begin
                        ac_q    <= step_ac(ac_q, instr.right, sel_cg);
                        pf_pend <= 1'b1;
                    end
                    OP_CLEAR: begin
                        ac_q     <= '0;
                        sel_cg   <= 1'b0;
                        fill_on  <= 1'b1;
                        fill_ptr <= '0;
                    end
                    default: ;
                endcase
            end
            if (dwr_acc | drd_acc) begin
                ac_q    <= step_ac(ac_q, 1'b1, sel_cg);
                pf_pend <= 1'b1;
            end
        end
    end

    // Data register prefetch and read return
    always_ff @(posedge clk) begin
        if (rst) begin
            dr_q      <= '0;
            acc_rdata <= '0;
        end else begin
            if (pf_pend) dr_q <= sel_cg ? cg_rbyte : dd_rbyte;
            if (stat_rd)
                acc_rdata <= {busy, 7'(ac_q)};
            else if (drd_any)
                acc_rdata <= dr_q;
        end
    end
endmodule

// File: rtl/chd_host_if_chk.sv
module chd_host_if_chk #(
    parameter int AC_W  = 7,
    parameter int CG_AW = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            acc_valid,
    input logic            acc_rs,
    input logic            acc_rnw,
    input logic [7:0]      acc_rdata,
    input logic            busy,
    input logic            instr_acc,
    input logic            sel_cg,
    input logic [AC_W-1:0] ac_q,
    input logic [7:0]      dr_q
);
    a_r6_status_byte: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_rs && acc_rnw) |=>
            acc_rdata == {$past(busy), 7'($past(ac_q))});

    a_r3_read_returns_dr: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_rs && acc_rnw) |=> acc_rdata == $past(dr_q));

    a_r5_frozen_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(ac_q) && $stable(sel_cg)));

    a_r8_busy_after_instr: assert property (@(posedge clk) disable iff (rst)
        instr_acc |=> busy);

    a_r7_pattern_range: assert property (@(posedge clk) disable iff (rst)
        sel_cg |-> ((ac_q >> CG_AW) == '0));
endmodule

bind chd_host_if chd_host_if_chk #(.AC_W(DD_AW), .CG_AW(CG_AW)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .acc_valid(acc_valid),
    .acc_rs   (acc_rs),
    .acc_rnw  (acc_rnw),
    .acc_rdata(acc_rdata),
    .busy     (busy),
    .instr_acc(instr_acc),
    .sel_cg   (sel_cg),
    .ac_q     (ac_q),
    .dr_q     (dr_q)
);

// File: tb/test_chd_host_if.sv
module test_chd_host_if;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 1'b0;
    logic       acc_rs = 1'b0;
    logic       acc_rnw = 1'b0;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] acc_rdata;

    logic       drv_chk = 1'b0;
    logic       fire_q = 1'b0;
    int         n_vec = 0;
    int         n_bad = 0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb[$];

    always #(PERIOD/2) clk = ~clk;

    chd_host_if i_chd_host_if (
        .clk      (clk),
        .rst      (rst),
        .acc_valid(acc_valid),
        .acc_rs   (acc_rs),
        .acc_rnw  (acc_rnw),
        .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata)
    );

    // Monitor: a checked read was presented before this edge
    always @(posedge clk) fire_q <= acc_valid && acc_rnw && drv_chk;

    always @(negedge clk) begin
        if (fire_q) begin
            item_t it;
            n_vec++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard empty: got %02h", acc_rdata);
            end else begin
                it = sb.pop_front();
                if (acc_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got %02h expected %02h", it.req, acc_rdata, it.exp);
                end
            end
        end
    end

    task automatic access(input logic rs, input logic rnw,
                          input logic [7:0] wd, input logic chk);
        @(negedge clk);
        acc_valid = 1'b1; acc_rs = rs; acc_rnw = rnw; acc_wdata = wd; drv_chk = chk;
        @(negedge clk);
        acc_valid = 1'b0; drv_chk = 1'b0;
    endtask

    task automatic instr(input logic [7:0] code);
        access(1'b0, 1'b0, code, 1'b0);
    endtask

    task automatic dwrite(input logic [7:0] b);
        access(1'b1, 1'b0, b, 1'b0);
    endtask

    task automatic expect_rd(input logic rs, input logic [7:0] exp, input string req);
        item_t it;
        it.exp = exp; it.req = req;
        sb.push_back(it);
        access(rs, 1'b1, 8'h00, 1'b1);
    endtask

    task automatic poll_free(output int n);
        n = 0;
        do begin
            access(1'b0, 1'b1, 8'h00, 1'b0);
            n++;
        end while (acc_rdata[7] && n < 1000);
        if (n >= 1000) begin
            n_bad++;
            $display("FAIL R8 busy never cleared: got %02h expected 00", acc_rdata);
        end
    endtask

    task automatic check_n(input int got, input int lo, input int hi, input string req);
        n_vec++;
        if (got < lo || got > hi) begin
            n_bad++;
            $display("FAIL %s: got %0d polls expected %0d..%0d", req, got, lo, hi);
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state (prefetch clock then idle)
        @(negedge clk);
        expect_rd(1'b0, 8'h00, "R1 reset status");

        // R9 clear: busy at once, long fill, counter zero
        instr(8'h01);
        expect_rd(1'b0, 8'h80, "R9 busy right after clear");
        poll_free(n);
        check_n(n, 60, 80, "R9 clear busy length");
        expect_rd(1'b0, 8'h00, "R9 counter zero after clear");

        // R2/R6 set display address 5, status while busy; R5 dropped write
        instr(8'h85);
        expect_rd(1'b0, 8'h85, "R6 status busy with address");
        instr(8'h89);
        poll_free(n);
        check_n(n, 1, 3, "R8 instruction busy length");
        expect_rd(1'b0, 8'h05, "R5 instruction dropped while busy");

        // R7 auto-increment on write; R8 one-clock data busy
        dwrite(8'h41);
        poll_free(n);
        check_n(n, 1, 1, "R8 data access busy length");
        dwrite(8'h42);
        poll_free(n);
        expect_rd(1'b0, 8'h07, "R7 counter after two writes");

        // R3 prefetch after address set and after auto-increment
        instr(8'h85);
        poll_free(n);
        expect_rd(1'b1, 8'h41, "R3 prefetch after address set");
        poll_free(n);
        expect_rd(1'b1, 8'h42, "R3 prefetch after increment");
        poll_free(n);
        expect_rd(1'b0, 8'h07, "R7 counter after two reads");

        // R4/R7 pattern memory: wrap at 64, separate from display memory
        instr(8'h7F);
        poll_free(n);
        dwrite(8'h1F);
        poll_free(n);
        expect_rd(1'b0, 8'h00, "R7 pattern counter wraps at 64");
        instr(8'h7F);
        poll_free(n);
        expect_rd(1'b1, 8'h1F, "R4 read from pattern memory");
        instr(8'hBF);
        poll_free(n);
        expect_rd(1'b1, 8'h20, "R4 display memory selected again");

        // R7 display wrap at 128
        instr(8'hFF);
        poll_free(n);
        dwrite(8'h55);
        poll_free(n);
        expect_rd(1'b0, 8'h00, "R7 display counter wraps at 128");
        instr(8'hFF);
        poll_free(n);
        expect_rd(1'b1, 8'h55, "R3 prefetch at last display byte");

        // R2/R7 cursor shift right and left with wrap
        instr(8'h8A);
        poll_free(n);
        instr(8'h14);
        poll_free(n);
        expect_rd(1'b0, 8'h0B, "R2 cursor shift right");
        instr(8'h80);
        poll_free(n);
        instr(8'h10);
        poll_free(n);
        expect_rd(1'b0, 8'h7F, "R7 cursor shift left wraps");

        // R2 unknown code is a no-op
        instr(8'h02);
        poll_free(n);
        expect_rd(1'b0, 8'h7F, "R2 unknown code leaves counter");

        // R5 data write while busy changes nothing
        instr(8'h94);
        dwrite(8'h77);
        poll_free(n);
        expect_rd(1'b0, 8'h14, "R5 busy data write keeps counter");
        expect_rd(1'b1, 8'h20, "R5 busy data write keeps memory");
        poll_free(n);
        expect_rd(1'b0, 8'h15, "R7 counter after read");

        // R5 data read while busy does not advance
        instr(8'h85);
        access(1'b1, 1'b1, 8'h00, 1'b0);
        poll_free(n);
        expect_rd(1'b0, 8'h05, "R5 busy data read keeps counter");

        // R9 second clear wipes written bytes, R4 clear selects display
        instr(8'h40);
        poll_free(n);
        instr(8'h01);
        poll_free(n);
        instr(8'h85);
        poll_free(n);
        expect_rd(1'b1, 8'h20, "R9 fill replaced written byte");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard leftover: got %0d expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule